// File: doc/BRIEF.md
# Pin Output Routing and Enable Stage

This block is the output stage for one logic block of sixteen I/O slices. Each slice takes the data bit and the product-term enable of one macrocell. That macrocell sits at a configured forward offset of zero to seven from the slice, and the index wraps around the group. An output-mode field can replace the routed data with the slice's own macrocell signal or with its own small sum term, but the routed enable always follows the offset. Each pin then picks its final enable from eight sources. Four of them are chip-wide enables.

A small controller resolves those chip-wide enables. Any logic block may drive any line of a shared enable bus. When several blocks drive one line, the lowest-numbered block wins. A line with no driver rests at its polarity bit. Each chip-wide enable applies its own polarity. The first two can take a dedicated input pin instead of their bus line. All pin outputs are registered and appear one clock after their inputs. Open-drain pins are supported.

Top module: `io_route_stage`

## Requirements
- R1: While reset is asserted, and until the first clock edge after reset is released, padOut, padOe and padOd are all zero.
- R2: In output mode 0, slice i outputs mcFeedback[(i + ofs) mod 16], where ofs is the 3-bit field routeOfs[3i+2:3i]. Slice 15 can therefore reach macrocells 15 and 0 to 6.
- R3: The routed enable of slice i comes from the same source macrocell s as its data. It equals mcPtEn[s] when ptEnUse[s] is 1 and is 0 otherwise.
- R4: In output mode 1, slice i outputs its own mcFeedback[i] whatever the offset, while the routed enable still comes from the offset source.
- R5: Output mode 2 outputs the slice's own mcSum5[i], and mode 3 outputs its inverse. The mode field is outMode[2i+1:2i].
- R6: The enable select enSel[3i+2:3i] picks the pin enable. Codes 0 to 3 take chip-wide enable 0 to 3. Code 4 takes the routed enable, code 5 its inverse, code 6 constant 1 and code 7 constant 0.
- R7: With openDrain[i]=0, padOut[i] is the selected data and padOe[i] is the selected enable. With openDrain[i]=1, padOut[i] is 0 and padOe[i] is the enable AND NOT the data. padOd[i] mirrors openDrain[i].
- R8: Bus line k is driven by block b when blkBusDrive[4b+k] is 1. Its value is blkShareEn of the lowest-numbered block that drives it.
- R9: A bus line with no driver takes the value gePol[k]. Chip-wide enable k is its source when gePol[k]=1 and the inverse of its source when gePol[k]=0.
- R10: For k in {0,1}, gePinSel[k]=1 makes dedPin[k] the source of chip-wide enable k instead of bus line k. Enables 2 and 3 always use bus lines 2 and 3.
- R11: Every output changes only at a rising clock edge. It reflects the inputs present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcFeedback | input | 16 | Macrocell output signal per slice |
| mcSum5 | input | 16 | Own five-term sum per slice |
| mcPtEn | input | 16 | Per-macrocell enable product term |
| ptEnUse | input | 16 | Enable term routed to output stage when 1 |
| routeOfs | input | 48 | 3-bit forward offset per slice |
| outMode | input | 32 | 2-bit output mode per slice |
| enSel | input | 48 | 3-bit pin enable select per slice |
| openDrain | input | 16 | Open-drain select per pin |
| blkShareEn | input | 4 | Shared enable term of each logic block |
| blkBusDrive | input | 16 | Block b drives bus line k at bit 4b+k |
| gePol | input | 4 | Polarity and idle value per chip-wide enable |
| gePinSel | input | 2 | Dedicated pin source for enables 0 and 1 |
| dedPin | input | 2 | Dedicated enable input pins |
| padOut | output | 16 | Registered pin data |
| padOe | output | 16 | Registered pin driver enable |
| padOd | output | 16 | Registered open-drain flag |

## Verification
The assertions assume that configuration inputs are stable across each clock edge they are checked at. They also assume that chip-wide enable checks hold only when the pin-select bits are clear for the line in question. The stimulus changes every input only on the falling edge, so each rising edge sees settled values. The arbitration sweeps clear gePinSel, and separate steps exercise the pin source. Offsets, modes and select codes are swept over their full ranges, together with generated data patterns that keep neighbouring macrocells distinct, so a wrong source index shows up as a data mismatch.

// File: rtl/io_route_pkg.sv
package io_route_pkg;

  localparam int GLB_EN_N = 4;
  localparam int PIN_EN_N = 2;

  typedef enum logic [1:0] {
    MODE_ROUTED = 2'd0,
    MODE_OWN    = 2'd1,
    MODE_SUM    = 2'd2,
    MODE_SUMINV = 2'd3
  } out_mode_e;

  typedef enum logic [2:0] {
    EN_GLB0   = 3'd0,
    EN_GLB1   = 3'd1,
    EN_GLB2   = 3'd2,
    EN_GLB3   = 3'd3,
    EN_PT     = 3'd4,
    EN_PTINV  = 3'd5,
    EN_HIGH   = 3'd6,
    EN_LOW    = 3'd7
  } en_sel_e;

  typedef struct packed {
    logic [GLB_EN_N-1:0] glbEn;
  } ctl_strobe_t;

endpackage

// File: rtl/io_glb_en_ctl.sv
module io_glb_en_ctl
  import io_route_pkg::*;
#(
  parameter int NUM_BLK = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_BLK-1:0]           blkShareEn,
  input  logic [NUM_BLK*GLB_EN_N-1:0]  blkBusDrive,
  input  logic [GLB_EN_N-1:0]          gePol,
  input  logic [PIN_EN_N-1:0]          gePinSel,
  input  logic [PIN_EN_N-1:0]          dedPin,
  output ctl_strobe_t                  strb
);

  logic [GLB_EN_N-1:0] lineVal;
  logic [GLB_EN_N-1:0] lineDriven;
  logic [GLB_EN_N-1:0] srcVal;

  // lowest-index driver wins: scan downward so the last hit is the smallest index
  always_comb begin
    for (int k = 0; k < GLB_EN_N; k++) begin
      lineVal[k]    = gePol[k];
      lineDriven[k] = 1'b0;
      for (int b = NUM_BLK-1; b >= 0; b--) begin
        if (blkBusDrive[b*GLB_EN_N + k]) begin
          lineVal[k]    = blkShareEn[b];
          lineDriven[k] = 1'b1;
        end
      end
    end
  end

  genvar k;
  generate
    for (k = 0; k < GLB_EN_N; k++) begin : g_src
      if (k < PIN_EN_N) begin : g_pin
        assign srcVal[k] = gePinSel[k] ? dedPin[k] : lineVal[k];
      end else begin : g_bus
        assign srcVal[k] = lineVal[k];
      end
      assign strb.glbEn[k] = gePol[k] ? srcVal[k] : ~srcVal[k];

      if (k >= PIN_EN_N) begin : g_chk
        // R8
        blk0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (blkBusDrive[k] && gePol[k]) |-> (strb.glbEn[k] == blkShareEn[0]));
        // R9
        idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (!lineDriven[k]) |-> strb.glbEn[k]);
      end
    end
  endgenerate

  // R10
  pin0_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gePinSel[0] && gePol[0]) |-> (strb.glbEn[0] == dedPin[0]));

endmodule

// File: rtl/io_route_dp.sv
module io_route_dp
  import io_route_pkg::*;
#(
  parameter int NUM_SLICE = 16,
  parameter int OFS_W     = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctl_strobe_t               strb,
  input  logic [NUM_SLICE-1:0]      mcFeedback,
  input  logic [NUM_SLICE-1:0]      mcSum5,
  input  logic [NUM_SLICE-1:0]      mcPtEn,
  input  logic [NUM_SLICE-1:0]      ptEnUse,
  input  logic [NUM_SLICE*OFS_W-1:0] routeOfs,
  input  logic [NUM_SLICE*2-1:0]    outMode,
  input  logic [NUM_SLICE*3-1:0]    enSel,
  input  logic [NUM_SLICE-1:0]      openDrain,
  output logic [NUM_SLICE-1:0]      padOut,
  output logic [NUM_SLICE-1:0]      padOe,
  output logic [NUM_SLICE-1:0]      padOd
);

  localparam int IDX_W = $clog2(NUM_SLICE);

  logic [NUM_SLICE-1:0] srcEnMasked;
  assign srcEnMasked = mcPtEn & ptEnUse;

  genvar i;
  generate
    for (i = 0; i < NUM_SLICE; i++) begin : g_slice
      logic [OFS_W-1:0] ofsI;
      logic [IDX_W:0]   srcFull;
      logic [IDX_W:0]   srcIdx;
      logic             routedData;
      logic             routedEn;
      logic             selData;
      logic             selEn;
      logic             nxtOut;
      logic             nxtOe;
      out_mode_e        modeI;
      en_sel_e          selI;

      assign ofsI    = routeOfs[i*OFS_W +: OFS_W];
      assign modeI   = out_mode_e'(outMode[i*2 +: 2]);
      assign selI    = en_sel_e'(enSel[i*3 +: 3]);
      assign srcFull = (IDX_W+1)'(i) + (IDX_W+1)'(ofsI);
      assign srcIdx  = (srcFull >= (IDX_W+1)'(NUM_SLICE)) ?
                       srcFull - (IDX_W+1)'(NUM_SLICE) : srcFull;

      assign routedData = mcFeedback[srcIdx[IDX_W-1:0]];
      assign routedEn   = srcEnMasked[srcIdx[IDX_W-1:0]];

      always_comb begin
        unique case (modeI)
          MODE_ROUTED: selData = routedData;
          MODE_OWN:    selData = mcFeedback[i];
          MODE_SUM:    selData = mcSum5[i];
          default:     selData = ~mcSum5[i];
        endcase
      end

      always_comb begin
        unique case (selI)
          EN_GLB0:  selEn = strb.glbEn[0];
          EN_GLB1:  selEn = strb.glbEn[1];
          EN_GLB2:  selEn = strb.glbEn[2];
          EN_GLB3:  selEn = strb.glbEn[3];
          EN_PT:    selEn = routedEn;
          EN_PTINV: selEn = ~routedEn;
          EN_HIGH:  selEn = 1'b1;
          default:  selEn = 1'b0;
        endcase
      end

      assign nxtOut = openDrain[i] ? 1'b0 : selData;
      assign nxtOe  = openDrain[i] ? (selEn & ~selData) : selEn;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          padOut[i] <= 1'b0;
          padOe[i]  <= 1'b0;
          padOd[i]  <= 1'b0;
        end else begin
          padOut[i] <= nxtOut;
          padOe[i]  <= nxtOe;
          padOd[i]  <= openDrain[i];
        end
      end

      // R6
      en_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enSel[i*3 +: 3] == 3'd6 && !openDrain[i]) |=> padOe[i]);
      // R6
      en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enSel[i*3 +: 3] == 3'd7) |=> !padOe[i]);
      // R7
      od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        openDrain[i] |=> (!padOut[i] && padOd[i]));
      // R4
      own_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outMode[i*2 +: 2] == 2'd1 && !openDrain[i]) |=> (padOut[i] == $past(mcFeedback[i])));
    end
  endgenerate

endmodule

// File: rtl/io_route_stage.sv
module io_route_stage
  import io_route_pkg::*;
#(
  parameter int NUM_SLICE = 16,
  parameter int OFS_W     = 3,
  parameter int NUM_BLK   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SLICE-1:0]          mcFeedback,
  input  logic [NUM_SLICE-1:0]          mcSum5,
  input  logic [NUM_SLICE-1:0]          mcPtEn,
  input  logic [NUM_SLICE-1:0]          ptEnUse,
  input  logic [NUM_SLICE*OFS_W-1:0]    routeOfs,
  input  logic [NUM_SLICE*2-1:0]        outMode,
  input  logic [NUM_SLICE*3-1:0]        enSel,
  input  logic [NUM_SLICE-1:0]          openDrain,
  input  logic [NUM_BLK-1:0]            blkShareEn,
  input  logic [NUM_BLK*GLB_EN_N-1:0]   blkBusDrive,
  input  logic [GLB_EN_N-1:0]           gePol,
  input  logic [PIN_EN_N-1:0]           gePinSel,
  input  logic [PIN_EN_N-1:0]           dedPin,
  output logic [NUM_SLICE-1:0]          padOut,
  output logic [NUM_SLICE-1:0]          padOe,
  output logic [NUM_SLICE-1:0]          padOd
);

  ctl_strobe_t strb;

  io_glb_en_ctl #(.NUM_BLK(NUM_BLK)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .blkShareEn (blkShareEn),
    .blkBusDrive(blkBusDrive),
    .gePol      (gePol),
    .gePinSel   (gePinSel),
    .dedPin     (dedPin),
    .strb       (strb)
  );

  io_route_dp #(.NUM_SLICE(NUM_SLICE), .OFS_W(OFS_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .mcFeedback (mcFeedback),
    .mcSum5     (mcSum5),
    .mcPtEn     (mcPtEn),
    .ptEnUse    (ptEnUse),
    .routeOfs   (routeOfs),
    .outMode    (outMode),
    .enSel      (enSel),
    .openDrain  (openDrain),
    .padOut     (padOut),
    .padOe      (padOe),
    .padOd      (padOd)
  );

endmodule

// File: tb/io_route_stage_tb.sv
module io_route_stage_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mcFeedback = '0, mcSum5 = '0, mcPtEn = '0, ptEnUse = '0, openDrain = '0;
  logic [47:0] routeOfs = '0, enSel = '0;
  logic [31:0] outMode = '0;
  logic [3:0]  blkShareEn = '0, gePol = '0;
  logic [15:0] blkBusDrive = '0;
  logic [1:0]  gePinSel = '0, dedPin = '0;
  logic [15:0] padOut, padOe, padOd;

  int nTests = 0, nFail = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  io_route_stage u_dut (
    .clk(clk), .rst_n(rst_n), .mcFeedback(mcFeedback), .mcSum5(mcSum5),
    .mcPtEn(mcPtEn), .ptEnUse(ptEnUse), .routeOfs(routeOfs), .outMode(outMode),
    .enSel(enSel), .openDrain(openDrain), .blkShareEn(blkShareEn),
    .blkBusDrive(blkBusDrive), .gePol(gePol), .gePinSel(gePinSel), .dedPin(dedPin),
    .padOut(padOut), .padOe(padOe), .padOd(padOd)
  );

  function automatic logic [15:0] nextRnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:16];
  endfunction

  function automatic logic glbModel(int k);
    logic v;
    v = gePol[k];
    for (int b = 3; b >= 0; b--) if (blkBusDrive[b*4+k]) v = blkShareEn[b];
    if (k < 2 && gePinSel[k]) v = dedPin[k];
    return gePol[k] ? v : ~v;
  endfunction

  task automatic expModel(output logic [15:0] eOut, output logic [15:0] eOe);
    for (int i = 0; i < 16; i++) begin
      int s;
      logic d, re, en;
      s  = (i + int'(routeOfs[i*3 +: 3])) % 16;
      re = mcPtEn[s] & ptEnUse[s];
      case (outMode[i*2 +: 2])
        2'd0: d = mcFeedback[s];
        2'd1: d = mcFeedback[i];
        2'd2: d = mcSum5[i];
        default: d = ~mcSum5[i];
      endcase
      case (enSel[i*3 +: 3])
        3'd4: en = re;
        3'd5: en = ~re;
        3'd6: en = 1'b1;
        3'd7: en = 1'b0;
        default: en = glbModel(int'(enSel[i*3 +: 3]));
      endcase
      eOut[i] = openDrain[i] ? 1'b0 : d;
      eOe[i]  = openDrain[i] ? (en & ~d) : en;
    end
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs set at negedge; wait one negedge so the rising edge in between registers them
  task automatic stepCheck(string req);
    logic [15:0] eOut, eOe;
    expModel(eOut, eOe);
    @(negedge clk);
    check({req, " data"}, padOut, eOut);
    check({req, " enable"}, padOe, eOe);
    check({req, " odflag"}, padOd, openDrain);
  endtask

  task automatic setUniform(int ofs, int mode, int sel);
    for (int i = 0; i < 16; i++) begin
      routeOfs[i*3 +: 3] = 3'(ofs);
      outMode[i*2 +: 2]  = 2'(mode);
      enSel[i*3 +: 3]    = 3'(sel);
    end
  endtask

  task automatic randData();
    mcFeedback = nextRnd();
    mcSum5     = nextRnd();
    mcPtEn     = nextRnd();
    ptEnUse    = nextRnd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    // R1 reset state, even with active-looking inputs
    setUniform(0, 0, 6);
    mcFeedback = 16'hFFFF;
    openDrain  = 16'h00FF;
    repeat (3) @(negedge clk);
    check("R1 out", padOut, 16'h0);
    check("R1 oe", padOe, 16'h0);
    check("R1 od", padOd, 16'h0);
    rst_n = 1'b1;
    openDrain = '0;

    // R2 R3 uniform offsets incl. wrap
    for (int ofs = 0; ofs < 8; ofs++) begin
      for (int p = 0; p < 4; p++) begin
        setUniform(ofs, 0, 4 + (p % 2));
        randData();
        stepCheck("R2 R3 uniform offset");
      end
    end
    // R2 single hot macrocell to pin down each source index
    for (int ofs = 0; ofs < 8; ofs++) begin
      for (int m = 0; m < 16; m++) begin
        setUniform(ofs, 0, 4);
        mcFeedback = 16'(1) << m;
        mcPtEn = 16'hFFFF;
        ptEnUse = 16'(1) << m;
        stepCheck("R2 R3 one-hot source");
      end
    end
    // R2 mixed per-slice offsets
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 16; i++) begin
        routeOfs[i*3 +: 3] = 3'((i * 3 + s) % 8);
        outMode[i*2 +: 2]  = 2'd0;
        enSel[i*3 +: 3]    = 3'd4;
      end
      randData();
      stepCheck("R2 mixed offsets");
    end

    // R4 R5 output modes, enable still routed
    for (int mode = 1; mode < 4; mode++) begin
      for (int ofs = 0; ofs < 8; ofs++) begin
        setUniform(ofs, mode, 4);
        randData();
        stepCheck(mode == 1 ? "R4 own feedback" : "R5 own sum");
      end
    end

    // R6 every enable select code
    blkBusDrive = 16'h0008;  // block 0 drives line 3 only
    blkShareEn  = 4'b0001;
    gePol       = 4'b1010;
    for (int sel = 0; sel < 8; sel++) begin
      for (int p = 0; p < 3; p++) begin
        setUniform(p, 0, sel);
        randData();
        stepCheck("R6 enable select");
      end
    end

    // R7 open-drain mix
    for (int p = 0; p < 8; p++) begin
      setUniform(p, p % 4, 4 + (p % 3));
      randData();
      openDrain = nextRnd();
      stepCheck("R7 open drain");
    end
    openDrain = '0;

    // R8 R9 bus arbitration sweep
    gePinSel = 2'b00;
    for (int k = 0; k < 4; k++) begin
      setUniform(0, 0, k);
      for (int d = 0; d < 16; d++) begin
        for (int e = 0; e < 16; e++) begin
          for (int pol = 0; pol < 2; pol++) begin
            blkBusDrive = '0;
            for (int b = 0; b < 4; b++) blkBusDrive[b*4+k] = d[b];
            blkShareEn = 4'(e);
            gePol = pol ? 4'hF : 4'h0;
            stepCheck(d == 0 ? "R9 idle line" : "R8 arbitration");
          end
        end
      end
    end

    // R10 dedicated pin source
    blkBusDrive = 16'hFFFF;
    blkShareEn  = 4'b0000;
    for (int k = 0; k < 4; k++) begin
      setUniform(0, 0, k);
      for (int v = 0; v < 16; v++) begin
        gePinSel = v[1:0];
        dedPin   = v[3:2];
        gePol    = 4'(v * 5);
        stepCheck("R10 pin source");
      end
    end

    // R11 outputs hold until the rising edge
    setUniform(0, 0, 6);
    mcFeedback = 16'hA5A5;
    @(negedge clk);
    mcFeedback = 16'h5A5A;
    setUniform(0, 0, 7);
    #2;
    check("R11 hold data", padOut, 16'hA5A5);
    check("R11 hold enable", padOe, 16'hFFFF);
    @(negedge clk);
    check("R11 update data", padOut, 16'h5A5A);
    check("R11 update enable", padOe, 16'h0000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule